// File: doc/BRIEF.md
# Dual-Edge Converter Sample Capture

This block sits directly behind an 8-bit, 250 MS/s converter that delivers its samples on two 8-bit buses against a 125 MHz source-synchronous clock. The converter's clock is also the block's own clock. One bus carries the sample that settles around the falling edge. The other carries the sample that settles around the rising edge. The block captures each bus on its own edge and moves the falling-edge half into the rising-edge domain. It then emits both samples together as one time-ordered 16-bit word with a valid strobe, so downstream logic sees one two-sample word per rising edge.

Within a clock period, the sample on bus A comes first: it is captured at the falling edge. The sample on bus B comes second: it is captured at the next rising edge. The output word holds the earlier sample (A) in bits [7:0] and the later sample (B) in bits [15:8]. A consecutive run of converter samples therefore reads as an increasing sequence from the low byte to the high byte, and on from one word to the next.

Top module: `dual_edge_capture`

## Requirements
- R1: `adc_a` is captured only at the falling clock edge. A change on `adc_a` between a falling edge and the following rising edge does not alter the output.
- R2: `adc_b` is captured only at the rising clock edge. A change on `adc_b` between a rising edge and the following falling edge does not alter the output.
- R3: `pair_data[7:0]` holds the A sample and `pair_data[15:8]` the B sample of the same pair. When a counting ramp is applied (A = 2k, B = 2k+1, modulo 256), every valid word has high byte = low byte + 1, and its low byte = previous valid word's high byte + 1.
- R4: Consider the A sample taken at the falling edge that follows rising edge n, and the B sample taken at rising edge n+1. This pair appears on `pair_data` after rising edge n+2, and both output ports change only at rising edges.
- R5: While reset is sampled high, `pair_valid` is 0. After reset is released, `pair_valid` stays 0 through the first rising edge that samples reset low and becomes 1 at the second such edge. It then stays 1 until reset is sampled again.
- R6: A rising edge that samples reset high clears `pair_data` to 0, and it reads 0 until real data reaches the output.
- R7: Asserting reset in the middle of a valid stream drops `pair_valid` at the next rising edge. After release, the same two-edge fill period from R5 repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter data clock, used as the capture clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_a | input | 8 | Converter bus A, settles at the falling edge |
| adc_b | input | 8 | Converter bus B, settles at the rising edge |
| pair_data | output | 16 | Ordered sample pair: A in [7:0], B in [15:8] |
| pair_valid | output | 1 | High when `pair_data` holds a captured pair |

## Verification
Take a pair whose A value is driven just after rising edge n and whose B value is driven just after the following falling edge. That pair is due on the output after rising edge n+2. Its valid strobe is due at the second edge that samples reset low, and the cleared word is due at the first edge that samples reset high. The bench keeps a per-cycle record of what it drove. It reads the outputs only at falling edges, half a period after the last rising edge, and compares them with the entry from two cycles earlier. To prove that the unused half-period is ignored, it overwrites each bus with junk right after that bus's capture edge.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int SAMPLE_W  = 8;
  localparam int VALID_LAG = 2;

  typedef struct packed {
    logic [SAMPLE_W-1:0] late;
    logic [SAMPLE_W-1:0] early;
  } sample_pair_t;
endpackage

// File: rtl/dec_fall_capture.sv
module dec_fall_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q_fall
);
  always_ff @(negedge clk) begin
    if (rst) q_fall <= '0;
    else     q_fall <= din;
  end
endmodule

// File: rtl/dec_rise_align.sv
module dec_rise_align #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fall_q,
  input  logic [W-1:0] din_rise,
  output logic [W-1:0] early_q,
  output logic [W-1:0] late_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= '0;
      late_q  <= '0;
    end else begin
      early_q <= fall_q;
      late_q  <= din_rise;
    end
  end

  // R1: the rising-edge stage takes whatever the falling stage last held
  assert_realign_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> early_q == $past(fall_q));
  // R2: bus B is taken at the rising edge
  assert_rise_capture_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> late_q == $past(din_rise));
endmodule

// File: rtl/dec_pair_out.sv
module dec_pair_out
  import dec_pkg::*;
#(
  parameter int W   = SAMPLE_W,
  parameter int LAG = VALID_LAG
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   early_q,
  input  logic [W-1:0]   late_q,
  output logic [2*W-1:0] word_q,
  output logic           valid_q
);
  localparam int CW = $clog2(LAG + 1);
  localparam logic [CW-1:0] LAG_C  = CW'(LAG);
  localparam logic [CW-1:0] LAST_C = CW'(LAG - 1);

  logic [CW-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
      valid_q  <= 1'b0;
      word_q   <= '0;
    end else begin
      if (fill_cnt != LAG_C) fill_cnt <= fill_cnt + 1'b1;
      valid_q <= (fill_cnt >= LAST_C);
      word_q  <= {late_q, early_q};
    end
  end

  // R5: the fill counter never passes its limit
  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= LAG_C);
  // R3: the earlier sample lands in the low byte
  assert_low_early_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> word_q[W-1:0] == $past(early_q));
  // R3: the later sample lands in the high byte
  assert_high_late_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> word_q[2*W-1:W] == $past(late_q));
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
  import dec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SAMPLE_W-1:0]   adc_a,
  input  logic [SAMPLE_W-1:0]   adc_b,
  output logic [2*SAMPLE_W-1:0] pair_data,
  output logic                  pair_valid
);
  logic [SAMPLE_W-1:0] a_fall;
  logic [SAMPLE_W-1:0] a_rise;
  logic [SAMPLE_W-1:0] b_rise;
  sample_pair_t        pair_q;

  dec_fall_capture #(.W(SAMPLE_W)) u_fall (
    .clk(clk), .rst(rst), .din(adc_a), .q_fall(a_fall)
  );

  dec_rise_align #(.W(SAMPLE_W)) u_align (
    .clk(clk), .rst(rst), .fall_q(a_fall), .din_rise(adc_b),
    .early_q(a_rise), .late_q(b_rise)
  );

  dec_pair_out #(.W(SAMPLE_W), .LAG(VALID_LAG)) u_out (
    .clk(clk), .rst(rst), .early_q(a_rise), .late_q(b_rise),
    .word_q(pair_q), .valid_q(pair_valid)
  );

  assign pair_data = pair_q;

  // R5, R7: a reset edge leaves the strobe low
  assert_reset_clears_valid_R7: assert property (@(posedge clk)
    rst |=> !pair_valid);
  // R6: a reset edge leaves the word cleared
  assert_reset_clears_data_R6: assert property (@(posedge clk)
    rst |=> pair_data == '0);
  // R5: once up, the strobe holds while reset stays low
  assert_valid_holds_R5: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> pair_valid);
endmodule

// File: tb/tb_dual_edge_capture.sv
module tb_dual_edge_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  adc_a = '0;
  logic [7:0]  adc_b = '0;
  logic [15:0] pair_data;
  logic        pair_valid;

  int total = 0;
  int bad   = 0;
  logic [7:0] a_hist [0:255];
  logic [7:0] b_hist [0:255];

  always #4 clk = ~clk;

  dual_edge_capture dut (
    .clk(clk), .rst(rst), .adc_a(adc_a), .adc_b(adc_b),
    .pair_data(pair_data), .pair_valid(pair_valid)
  );

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] expect_pair(input int i);
    return {b_hist[i], a_hist[i]};
  endfunction

  // mode 0: ramp from base, 1: random, 2: extremes
  task automatic fill(input int mode, input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: begin a_hist[i] = 8'(base + 2*i); b_hist[i] = 8'(base + 2*i + 1); end
        1: begin a_hist[i] = 8'($urandom); b_hist[i] = 8'($urandom); end
        default: begin a_hist[i] = (i % 2) ? 8'hFF : 8'h00; b_hist[i] = ~a_hist[i]; end
      endcase
    end
  endtask

  task automatic run_phase(input int mode, input int n, input logic [7:0] base);
    logic [7:0] prev_high;
    logic       prev_ok;
    fill(mode, n, base);
    // R7: reset in the middle of a stream
    @(negedge clk); #1 rst = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); #1;
      check("R7 valid in reset", {16'h0, pair_valid}, 17'h0);
      check("R6 data in reset", {1'b0, pair_data}, 17'h0);
    end
    prev_ok = 1'b0;
    prev_high = '0;
    for (int i = 0; i < n + 2; i++) begin
      @(posedge clk); #1;
      rst = 1'b0;
      adc_a = (i < n) ? a_hist[i] : 8'h00;
      adc_b = 8'($urandom);               // R2: junk before falling edge
      @(negedge clk); #1;
      if (i < 2) begin
        check("R5 valid during fill", {16'h0, pair_valid}, 17'h0);
        check("R6 data during fill", {1'b0, pair_data}, 17'h0);
      end else begin
        check("R5 valid after fill", {16'h0, pair_valid}, 17'h1);
        check("R1 R2 R3 R4 pair", {1'b0, pair_data}, {1'b0, expect_pair(i - 2)});
        if (mode == 0) begin
          check("R3 ramp inside word", {9'h0, pair_data[15:8]}, {9'h0, 8'(pair_data[7:0] + 1)});
          if (prev_ok)
            check("R3 ramp across words", {9'h0, pair_data[7:0]}, {9'h0, 8'(prev_high + 1)});
          prev_high = pair_data[15:8];
          prev_ok = 1'b1;
        end
      end
      adc_b = (i < n) ? b_hist[i] : 8'h00;
      adc_a = 8'($urandom);               // R1: junk before rising edge
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R5 reset valid", {16'h0, pair_valid}, 17'h0);
    check("R6 reset data", {1'b0, pair_data}, 17'h0);
    run_phase(0, 40, 8'h00);
    run_phase(0, 20, 8'hF0);   // ramp wrapping through FF
    run_phase(1, 120, 8'h00);
    run_phase(2, 16, 8'h00);
    run_phase(1, 60, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule